// File: doc/BRIEF.md
# Dual-Array Sparse Gate Multiply-Accumulate Unit

This block produces the pre-activation value of one gate row of a recurrent cell whose two weight matrices were pruned to a fixed number of nonzeros per row. One matrix multiplies the layer input and the other multiplies the previous hidden state. The two matrices keep different nonzero counts, so the block has two multiplier arrays of unequal width that work in the same cycle. A wide array has `LANES_BIG` lanes and a narrow one has `LANES_SMALL` lanes. The lane ratio matches the ratio of the per-row nonzero counts, so both matrices finish a row in the same number of beats and neither array sits idle.

Each beat carries one word of weight/operand pairs for each matrix. A route selector sends the denser matrix to the wide array. The products of both arrays are joined and reduced by a tree of three-input adders. The tree output is summed across the beats of the row, and the bias is added after the last beat. All data are signed fixed point of `DW` bits with `FRAC` fraction bits. Every multiply and add is cut back to `DW` bits and saturates instead of wrapping. A small two-state controller marks the first beat of each row. In `ST_IDLE` no row is open. A beat that is not the last moves it to `ST_ROW`. A beat with the last flag in `ST_ROW` returns it to `ST_IDLE`. A row of a single beat leaves it in `ST_IDLE`.

Top module: `sparse_gate_mac`

## Requirements
- R1: Each lane product is the signed product of weight and operand, shifted right arithmetically by `FRAC` bits, which rounds toward minus infinity. A value outside the `DW`-bit range becomes 0x7FFF (positive) or 0x8000 (negative) for `DW`=16.
- R2: With `route_swap`=0, lanes 0..`LANES_BIG`-1 of the input-matrix stream (`xw_lanes`/`xd_lanes`) feed the wide array and lanes 0..`LANES_SMALL`-1 of the recurrent stream (`hw_lanes`/`hd_lanes`) feed the narrow array. With `route_swap`=1 the roles of the two streams are exchanged. Lane k sits in bits [k*DW +: DW].
- R3: Lanes at or above `LANES_SMALL` of the stream routed to the narrow array have no effect on the result.
- R4: The tree orders its inputs as wide-array lanes 0..`LANES_BIG`-1 followed by narrow-array lanes 0..`LANES_SMALL`-1. At each level it sums consecutive groups of three (the last group padded with zero) and saturates each group sum to `DW` bits. Levels repeat until one value remains.
- R5: The tree outputs of all beats of a row are summed. The first beat of a row, taken in `ST_IDLE`, starts from zero, so no earlier row leaks in.
- R6: The `bias` value present with the last beat of a row is added to the row sum after accumulation.
- R7: The accumulation and the bias add saturate to the `DW`-bit limits rather than wrapping.
- R8: `out_valid` is a one-cycle pulse. It is high during the cycle that follows the third rising edge after the edge that samples the last beat. `result` changes only together with that pulse and holds otherwise.
- R9: The controller goes `ST_IDLE`→`ST_ROW` on a beat that is not the last and `ST_ROW`→`ST_IDLE` on a last beat. Rows may follow each other with no idle cycle, and each row still yields its own pulse and value.
- R10: After reset `out_valid` is 0, `result` is 0 and the controller is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A beat of weight/operand pairs is present |
| beat_last | input | 1 | This beat ends the row |
| route_swap | input | 1 | 0: input matrix on wide array; 1: recurrent matrix on wide array |
| xw_lanes | input | LANES_BIG*DW | Input-matrix weights, one lane per DW bits |
| xd_lanes | input | LANES_BIG*DW | Layer-input operands matching `xw_lanes` |
| hw_lanes | input | LANES_BIG*DW | Recurrent-matrix weights |
| hd_lanes | input | LANES_BIG*DW | Previous hidden-state operands matching `hw_lanes` |
| bias | input | DW | Row bias, taken with the last beat |
| out_valid | output | 1 | One-cycle pulse marking a finished row |
| result | output | DW | Saturated pre-activation value of the row |

## Verification
The bench targets the corners where a wrong implementation shows. A fractional product of a negative value shows whether the shift floors or truncates toward zero. A route swap with junk in the unused upper lanes of the narrow-routed stream shows whether those lanes are ignored. Large mixed-sign lanes that saturate inside their groups of three show whether a tree that summed without grouping returns 0 instead of -1. Two further cases look for accumulator wrap and stale carry-over. In the first, the accumulator is driven past full scale: a wrapping design turns negative. In the second, two rows follow with no gap: a design that does not restart on the first beat adds one row into the next, and one that shares a single bias register reports the wrong bias for the first row.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ROW  = 1'b1
    } row_state_e;

endpackage

// File: rtl/sgm_lane_mul.sv
module sgm_lane_mul #(
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   wt,
    input  logic [LANES*DW-1:0]   dat,
    output logic [LANES*DW-1:0]   prod_q
);

    localparam int PW = 2 * DW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [PW-1:0] full;
        logic signed [PW-1:0] shr;
        logic        [DW-1:0] clip;
        logic        [DW-1:0] lane_q;

        always_comb begin
            full = $signed(wt[l*DW +: DW]) * $signed(dat[l*DW +: DW]);
            shr  = full >>> FRAC;
            if ((&shr[PW-1:DW-1]) || !(|shr[PW-1:DW-1])) begin
                clip = shr[DW-1:0];
            end else if (shr[PW-1]) begin
                clip = {1'b1, {(DW-1){1'b0}}};
            end else begin
                clip = {1'b0, {(DW-1){1'b1}}};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (in_valid) begin
                lane_q <= clip;
            end
        end

        assign prod_q[l*DW +: DW] = lane_q;

        AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (wt[l*DW +: DW] == '0)) |=> (prod_q[l*DW +: DW] == '0)); // R1
    end

endmodule

// File: rtl/sgm_sum_tree.sv
module sgm_sum_tree #(
    parameter int DW = 16,
    parameter int N  = 6
) (
    input  logic [N*DW-1:0] terms,
    output logic [DW-1:0]   total
);

    localparam int LEVELS = $clog2(N) + 1;

    function automatic logic [DW-1:0] sat3(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic [DW-1:0] c);
        logic [DW+1:0] s;
        s = {{2{a[DW-1]}}, a} + {{2{b[DW-1]}}, b} + {{2{c[DW-1]}}, c};
        if ((&s[DW+1:DW-1]) || !(|s[DW+1:DW-1])) begin
            return s[DW-1:0];
        end else if (s[DW+1]) begin
            return {1'b1, {(DW-1){1'b0}}};
        end else begin
            return {1'b0, {(DW-1){1'b1}}};
        end
    endfunction

    logic [DW-1:0] node [N];
    logic [DW-1:0] op_b;
    logic [DW-1:0] op_c;
    int            cnt;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            node[i] = terms[i*DW +: DW];
        end
        cnt  = N;
        op_b = '0;
        op_c = '0;
        for (int lv = 0; lv < LEVELS; lv++) begin
            if (cnt > 1) begin
                for (int j = 0; j < N; j++) begin
                    if (j < (cnt + 2) / 3) begin
                        op_b = ((3*j + 1) < cnt) ? node[3*j + 1] : '0;
                        op_c = ((3*j + 2) < cnt) ? node[3*j + 2] : '0;
                        node[j] = sat3(node[3*j], op_b, op_c);
                    end
                end
                cnt = (cnt + 2) / 3;
            end
        end
        total = node[0];
    end

endmodule

// File: rtl/sgm_row_ctrl.sv
module sgm_row_ctrl
    import sgm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_last,
    output logic first_beat
);

    row_state_e st;
    row_state_e st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (beat_valid && !beat_last) st_nxt = ST_ROW;
            ST_ROW:  if (beat_valid && beat_last)  st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        first_beat = beat_valid && (st == ST_IDLE);
    end

    AST_ROW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |=> (st == ST_IDLE)); // R9
    AST_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (st == ST_ROW)); // R9

endmodule

// File: rtl/sparse_gate_mac.sv
module sparse_gate_mac #(
    parameter int DW          = 16,
    parameter int FRAC        = 8,
    parameter int LANES_BIG   = 4,
    parameter int LANES_SMALL = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat_valid,
    input  logic                      beat_last,
    input  logic                      route_swap,
    input  logic [LANES_BIG*DW-1:0]   xw_lanes,
    input  logic [LANES_BIG*DW-1:0]   xd_lanes,
    input  logic [LANES_BIG*DW-1:0]   hw_lanes,
    input  logic [LANES_BIG*DW-1:0]   hd_lanes,
    input  logic [DW-1:0]             bias,
    output logic                      out_valid,
    output logic [DW-1:0]             result
);

    localparam int TOT_LANES = LANES_BIG + LANES_SMALL;
    localparam int BIG_W     = LANES_BIG * DW;
    localparam int SMALL_W   = LANES_SMALL * DW;

    function automatic logic [DW-1:0] sat2(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
        logic [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] == s[DW-1]) begin
            return s[DW-1:0];
        end else if (s[DW]) begin
            return {1'b1, {(DW-1){1'b0}}};
        end else begin
            return {1'b0, {(DW-1){1'b1}}};
        end
    endfunction

    // route selector
    logic [BIG_W-1:0]   big_w, big_d;
    logic [SMALL_W-1:0] small_w, small_d;

    always_comb begin
        if (route_swap) begin
            big_w   = hw_lanes;
            big_d   = hd_lanes;
            small_w = xw_lanes[SMALL_W-1:0];
            small_d = xd_lanes[SMALL_W-1:0];
        end else begin
            big_w   = xw_lanes;
            big_d   = xd_lanes;
            small_w = hw_lanes[SMALL_W-1:0];
            small_d = hd_lanes[SMALL_W-1:0];
        end
    end

    logic first_beat;

    sgm_row_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .first_beat (first_beat)
    );

    logic [BIG_W-1:0]   big_prod;
    logic [SMALL_W-1:0] small_prod;

    sgm_lane_mul #(.DW(DW), .FRAC(FRAC), .LANES(LANES_BIG)) u_big (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (beat_valid),
        .wt       (big_w),
        .dat      (big_d),
        .prod_q   (big_prod)
    );

    sgm_lane_mul #(.DW(DW), .FRAC(FRAC), .LANES(LANES_SMALL)) u_small (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (beat_valid),
        .wt       (small_w),
        .dat      (small_d),
        .prod_q   (small_prod)
    );

    // stage 1 side band
    logic          s1_valid, s1_last, s1_first;
    logic [DW-1:0] s1_bias;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_first <= 1'b0;
            s1_bias  <= '0;
        end else begin
            s1_valid <= beat_valid;
            s1_last  <= beat_last;
            s1_first <= first_beat;
            s1_bias  <= bias;
        end
    end

    // adder tree: wide lanes low, narrow lanes high
    logic [TOT_LANES*DW-1:0] joined;
    logic [DW-1:0]           tree_sum;
    logic                    prods_nonneg;

    assign joined = {small_prod, big_prod};

    always_comb begin
        prods_nonneg = 1'b1;
        for (int k = 0; k < TOT_LANES; k++) begin
            if (joined[k*DW + DW - 1]) prods_nonneg = 1'b0;
        end
    end

    sgm_sum_tree #(.DW(DW), .N(TOT_LANES)) u_tree (
        .terms (joined),
        .total (tree_sum)
    );

    // stage 2
    logic          s2_valid, s2_last, s2_first;
    logic [DW-1:0] s2_bias, tree_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_last  <= 1'b0;
            s2_first <= 1'b0;
            s2_bias  <= '0;
            tree_q   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_last  <= s1_last;
            s2_first <= s1_first;
            s2_bias  <= s1_bias;
            if (s1_valid) tree_q <= tree_sum;
        end
    end

    AST_TREE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && prods_nonneg) |=> !tree_q[DW-1]); // R4

    // stage 3: accumulator
    logic          s3_fin;
    logic [DW-1:0] s3_bias, acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            s3_fin  <= 1'b0;
            s3_bias <= '0;
        end else begin
            s3_fin  <= s2_valid && s2_last;
            s3_bias <= s2_bias;
            if (s2_valid) begin
                acc <= s2_first ? tree_q : sat2(acc, tree_q);
            end
        end
    end

    // stage 4: bias add
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s3_fin;
            if (s3_fin) result <= sat2(acc, s3_bias);
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(beat_valid && beat_last, 4)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result)); // R8

endmodule

// File: tb/sim_sparse_gate_mac.sv
`timescale 1ns/1ps
module sim_sparse_gate_mac;

    localparam int DW = 16;
    localparam int LB = 4;
    localparam int LS = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             beat_valid = 1'b0;
    logic             beat_last = 1'b0;
    logic             route_swap = 1'b0;
    logic [LB*DW-1:0] xw_lanes = '0, xd_lanes = '0, hw_lanes = '0, hd_lanes = '0;
    logic [DW-1:0]    bias = '0;
    logic             out_valid;
    logic [DW-1:0]    result;

    always #4 clk = ~clk;

    sparse_gate_mac u0 (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_last(beat_last),
        .route_swap(route_swap), .xw_lanes(xw_lanes), .xd_lanes(xd_lanes),
        .hw_lanes(hw_lanes), .hd_lanes(hd_lanes), .bias(bias),
        .out_valid(out_valid), .result(result)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;
    int  gxw[LB], gxd[LB], ghw[LB], ghd[LB];
    bit  gswap;
    int  gbias;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int mulq(input int w, input int d);
        int p;
        p = w * d;
        return sat16(p >>> 8);
    endfunction

    function automatic int beat_model();
        int v[6];
        int cnt, b, c;
        for (int l = 0; l < LB; l++)
            v[l] = gswap ? mulq(ghw[l], ghd[l]) : mulq(gxw[l], gxd[l]);
        for (int l = 0; l < LS; l++)
            v[LB+l] = gswap ? mulq(gxw[l], gxd[l]) : mulq(ghw[l], ghd[l]);
        cnt = 6;
        while (cnt > 1) begin
            for (int j = 0; j < (cnt + 2) / 3; j++) begin
                b = (3*j + 1 < cnt) ? v[3*j + 1] : 0;
                c = (3*j + 2 < cnt) ? v[3*j + 2] : 0;
                v[j] = sat16(v[3*j] + b + c);
            end
            cnt = (cnt + 2) / 3;
        end
        return v[0];
    endfunction

    task automatic clear_lanes();
        for (int l = 0; l < LB; l++) begin
            gxw[l] = 0; gxd[l] = 0; ghw[l] = 0; ghd[l] = 0;
        end
        gswap = 0;
        gbias = 0;
    endtask

    task automatic push(input bit last);
        @(negedge clk);
        beat_valid = 1'b1;
        beat_last  = last;
        route_swap = gswap;
        bias       = DW'(gbias);
        for (int l = 0; l < LB; l++) begin
            xw_lanes[l*DW +: DW] = DW'(gxw[l]);
            xd_lanes[l*DW +: DW] = DW'(gxd[l]);
            hw_lanes[l*DW +: DW] = DW'(ghw[l]);
            hd_lanes[l*DW +: DW] = DW'(ghd[l]);
        end
    endtask

    task automatic expect_out(input int exp, input string req);
        @(negedge clk);
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        check(out_valid == 1'b0, {req, " R8 early1"}, int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, {req, " R8 early2"}, int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, {req, " R8 early3"}, int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, {req, " R8 pulse"}, int'(out_valid), 1);
        check($signed(result) == exp, req, int'($signed(result)), exp);
        @(negedge clk);
        check(out_valid == 1'b0, {req, " R8 one cycle"}, int'(out_valid), 0);
        check($signed(result) == exp, {req, " R8 hold"}, int'($signed(result)), exp);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        check(result == '0, "R10 result", int'(result), 0);
    endtask

    task automatic t_route();
        clear_lanes();
        for (int l = 0; l < LB; l++) begin gxw[l] = 256; gxd[l] = l + 1; end
        ghw[0] = 512; ghw[1] = 512; ghd[0] = 1; ghd[1] = 1;
        gbias = 5;
        push(1);
        expect_out(19, "R2 R6 route0");
        gswap = 1;
        push(1);
        expect_out(12, "R2 route1");
    endtask

    task automatic t_frac();
        clear_lanes();
        gxw[0] = 128; gxd[0] = 3;
        gxw[1] = -128; gxd[1] = 3;
        push(1);
        expect_out(-1, "R1 floor shift");
    endtask

    task automatic t_ignore();
        int e;
        clear_lanes();
        for (int l = 0; l < LB; l++) begin gxw[l] = 256; gxd[l] = 10; end
        ghw[0] = 256; ghd[0] = 7;
        ghw[2] = 30000; ghd[2] = 30000; ghw[3] = -999; ghd[3] = 500;
        e = beat_model();
        push(1);
        expect_out(47, "R3 swap0 upper h lanes");
        check(e == 47, "R3 model", e, 47);
        gswap = 1;
        for (int l = 0; l < LB; l++) begin ghw[l] = 256; ghd[l] = 2; end
        gxw[0] = 256; gxd[0] = 1; gxw[1] = 256; gxd[1] = 1;
        gxw[2] = 30000; gxd[2] = 30000; gxw[3] = 30000; gxd[3] = -30000;
        push(1);
        expect_out(10, "R3 swap1 upper x lanes");
    endtask

    task automatic t_tree();
        clear_lanes();
        gxw[0] = 256; gxd[0] = 20000;
        gxw[1] = 256; gxd[1] = 20000;
        gxw[2] = 256; gxd[2] = 20000;
        gxw[3] = 256; gxd[3] = -20000;
        ghw[0] = 256; ghd[0] = -20000;
        ghw[1] = 256; ghd[1] = -20000;
        push(1);
        expect_out(-1, "R4 grouped saturation");
    endtask

    task automatic t_mulsat();
        clear_lanes();
        gxw[0] = 32767; gxd[0] = 32767;
        push(1);
        expect_out(32767, "R1 R7 product sat high");
        clear_lanes();
        gxw[0] = -32768; gxd[0] = 32767;
        gbias = -5;
        push(1);
        expect_out(-32768, "R1 R7 product sat low");
    endtask

    task automatic t_accum();
        int sum;
        clear_lanes();
        for (int l = 0; l < LB; l++) begin gxw[l] = 256; gxd[l] = l + 1; end
        ghw[1] = -256; ghd[1] = 3;
        sum = 0;
        for (int b = 0; b < 3; b++) begin
            push(b == 2);
            sum += beat_model();
        end
        expect_out(sum, "R5 three beats");
        check(sum == 21, "R5 model", sum, 21);
        push(1);
        expect_out(7, "R5 fresh row");
    endtask

    task automatic t_accsat();
        clear_lanes();
        for (int l = 0; l < LB; l++) begin gxw[l] = 256; gxd[l] = 5000; end
        ghw[0] = 256; ghd[0] = 5000; ghw[1] = 256; ghd[1] = 5000;
        push(0);
        push(0);
        gbias = -100;
        push(1);
        expect_out(32667, "R7 R6 accumulator saturation");
    endtask

    task automatic t_b2b();
        clear_lanes();
        for (int l = 0; l < LB; l++) begin gxw[l] = 256; gxd[l] = l + 1; end
        gbias = 1;
        push(1);
        for (int l = 0; l < LB; l++) gxd[l] = 100;
        gbias = 2;
        push(1);
        @(negedge clk);
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 first row pulse", int'(out_valid), 1);
        check($signed(result) == 11, "R9 first row value", int'($signed(result)), 11);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 second row pulse", int'(out_valid), 1);
        check($signed(result) == 402, "R9 second row value", int'($signed(result)), 402);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 pulses end", int'(out_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_frac();
        t_ignore();
        t_tree();
        t_mulsat();
        t_accum();
        t_accsat();
        t_b2b();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule